// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word select, serial data) into 16-bit words that a processor or DMA engine reads one at a time. All three serial lines are treated as ordinary inputs synchronous to the system clock. A rising bit-clock edge is found by comparing the bit clock with its value one system clock earlier. Four framing standards are supported: the standard stereo format (MSB one bit after the word-select change), left-justified, right-justified, and PCM with a short frame-sync pulse. Sample widths are 16, 24 or 32 bits, and each channel slot is 16 or 32 bits long.

Each captured sample is tagged with its channel and placed in a 16-bit read register, and a ready flag is raised. A sample wider than 16 bits becomes two words, read back to back: the high part first, then the low part. If a new sample arrives while a word is still unread, the new sample is dropped and a sticky overrun flag is set. The flag clears only when a status read is followed by a data read.

The framing state machine `sarx_framer` has five states. `FR_OFF` holds while disabled. `FR_PRIME` learns the idle word-select level (slave only). `FR_HUNT` waits for the first frame boundary. `FR_ARMED` spends one bit waiting for a delayed MSB. `FR_SHIFT` collects bits. Its transitions are:
- enable: OFF→PRIME (slave) or OFF→HUNT (master).
- first rise: PRIME→HUNT.
- boundary: HUNT/SHIFT→ARMED in the standard and PCM modes, or HUNT/SHIFT→SHIFT (restart) in the justified modes.
- next rise: ARMED→SHIFT.
- disable: any state→OFF.

The read-side machine `sarx_rxreg` has three states:
- `RX_EMPTY`: no word is held.
- `RX_ONE`: one word is held.
- `RX_TWO`: one word is held and a second word is queued.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is taken at each rising edge of `sck`, most significant bit first. In left-justified mode (`std_sel`=1) the MSB is the first bit whose `ws` differs from the previous bit, and the sample is the first N bits of the slot.
- R2: In standard mode (`std_sel`=0) the bit on which `ws` first changes still belongs to the previous slot, and the MSB arrives on the next rise.
- R3: Each word carries its channel on `rx_right`: 0 when `ws` was low for that slot (left), 1 when high (right). Both words of a wide sample carry the same tag.
- R4: In right-justified mode (`std_sel`=2) the sample is the last N bits of the slot. The slot is 32 bits when `slot32`=1 or the sample is wider than 16 bits, otherwise 16 bits.
- R5: In PCM mode (`std_sel`=3) a rising `ws` marks the frame, the MSB follows on the next rise, and `rx_right` is always 0.
- R6: `rx_ready` rises the cycle after a sample is accepted. It stays high until a data read empties the register.
- R7: With `fmt_sel`=1 (24 bits) the sample is delivered as word 1 = bits 23..8 and word 2 = bits 7..0 followed by eight zeros. With `fmt_sel`=2 (32 bits) it is delivered as bits 31..16, then bits 15..0. The second word appears at once when the first is read. With `fmt_sel`=0 the sample is one word.
- R8: A sample that arrives while a word is held and not being read, or while a second word is still queued, is discarded. `rx_word` is left unchanged and `rx_overrun` is set.
- R9: `rx_overrun` stays set through data reads alone. It clears on a data read that follows a `rd_status` pulse taken while the flag was set.
- R10: In slave mode (`master`=0) no data is captured before the first `ws` change (or, in PCM, the first `ws` rise) seen after enable. In master mode, enable is itself a frame boundary with `ws` expected low (in PCM, the first high `ws` marks the frame).
- R11: After reset `rx_word`=0 and `rx_ready`, `rx_right` and `rx_overrun` are 0.
- R12: While `en`=0, serial activity produces no sample: `rx_ready` stays low and `rx_word` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| master | input | 1 | 1: master timing, 0: slave with alignment wait |
| std_sel | input | 2 | 0 standard, 1 left-justified, 2 right-justified, 3 PCM |
| fmt_sel | input | 2 | 0: 16-bit, 1: 24-bit, 2: 32-bit sample |
| slot32 | input | 1 | 1: 32-bit slot, 0: 16-bit slot |
| sck | input | 1 | Serial bit clock, synchronous to clk |
| ws | input | 1 | Word select / frame sync |
| sd | input | 1 | Serial data |
| rd_status | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| rx_word | output | 16 | Read register |
| rx_ready | output | 1 | Word available (request line) |
| rx_right | output | 1 | Channel of the current word |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sweeps every combination of standard, sample width, slot length and master/slave. It fills the bits outside the sample with ones, so a receiver that takes the wrong window returns corrupted words. Slave runs begin mid-frame with a complete-looking slot of garbage, and a receiver that does not wait for alignment produces an extra word. Wide samples check the order of the two halves and the zero padding of 24-bit data. Overrun runs leave the register unread, both with a single word held and with a second word queued. They confirm that the held word survives and that only the status-then-data sequence clears the flag.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'd0,
        STD_LEFT    = 2'd1,
        STD_RIGHT   = 2'd2,
        STD_PCM     = 2'd3
    } std_e;

    typedef enum logic [1:0] {
        FMT_16 = 2'd0,
        FMT_24 = 2'd1,
        FMT_32 = 2'd2
    } fmt_e;

    typedef enum logic [2:0] {
        FR_OFF,
        FR_PRIME,
        FR_HUNT,
        FR_ARMED,
        FR_SHIFT
    } fr_state_e;

    typedef enum logic [1:0] {
        RX_EMPTY,
        RX_ONE,
        RX_TWO
    } rx_state_e;

    // Sample width in bits for a format code; the spare code behaves as 32.
    function automatic int unsigned sample_bits(input logic [1:0] f);
        unique case (f)
            FMT_16:  return 16;
            FMT_24:  return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sarx_framer.sv
module sarx_framer
    import sarx_pkg::*;
#(
    parameter int SMP_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             master,
    input  logic [1:0]       std_sel,
    input  logic [1:0]       fmt_sel,
    input  logic             slot32,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    output logic             smp_valid,
    output logic [SMP_W-1:0] smp_word,
    output logic             smp_right
);
    localparam int CNT_W = $clog2(SMP_W) + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    fr_state_e        st_q, st_d;
    logic             sck_q, ws_last, chan_q;
    logic             rise, ws_flip, late_msb, pcm, rjust;
    logic             start_now, take_old;
    logic [CNT_W-1:0] cnt_q, idx, cap_idx;
    logic [SMP_W-1:0] sh_q, full;
    int unsigned      nbits, slot_len;

    assign pcm      = (std_sel == STD_PCM);
    assign rjust    = (std_sel == STD_RIGHT);
    assign late_msb = (std_sel == STD_PHILIPS) || pcm;
    assign rise     = sck && !sck_q;
    assign ws_flip  = pcm ? (ws && !ws_last) : (ws != ws_last);
    assign nbits    = sample_bits(fmt_sel);
    assign slot_len = (slot32 || (nbits > HALF_W)) ? SMP_W : HALF_W;
    assign cap_idx  = rjust ? CNT_W'(slot_len - 1) : CNT_W'(nbits - 1);
    assign idx      = (cnt_q == CNT_TOP) ? CNT_TOP : cnt_q + 1'b1;
    assign full     = {sh_q[SMP_W-2:0], sd};

    // A new slot starts on this bit: right after an armed boundary, or on a
    // boundary bit itself when the MSB is not delayed.
    assign start_now = rise && ((st_q == FR_ARMED) ||
                       (((st_q == FR_HUNT) || (st_q == FR_SHIFT)) && ws_flip && !late_msb));
    // The bit belongs to the slot being collected.
    assign take_old  = rise && (st_q == FR_SHIFT) && (!ws_flip || late_msb);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_OFF;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = FR_OFF;
        end else begin
            unique case (st_q)
                FR_OFF:   st_d = master ? FR_HUNT : FR_PRIME;
                FR_PRIME: if (rise) st_d = FR_HUNT;
                FR_HUNT:  if (rise && ws_flip) st_d = late_msb ? FR_ARMED : FR_SHIFT;
                FR_ARMED: if (rise) st_d = FR_SHIFT;
                FR_SHIFT: if (rise && ws_flip) st_d = late_msb ? FR_ARMED : FR_SHIFT;
                default:  st_d = FR_OFF;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            ws_last   <= 1'b1;
            chan_q    <= 1'b0;
            cnt_q     <= CNT_TOP;
            sh_q      <= '0;
            smp_valid <= 1'b0;
            smp_word  <= '0;
            smp_right <= 1'b0;
        end else begin
            sck_q     <= sck;
            smp_valid <= 1'b0;
            if (st_q == FR_OFF)  ws_last <= !pcm;
            else if (rise)       ws_last <= ws;
            if (en) begin
                if (rise && ws_flip && ((st_q == FR_HUNT) || (st_q == FR_SHIFT)))
                    chan_q <= pcm ? 1'b0 : ws;
                if (start_now) begin
                    sh_q  <= {{(SMP_W-1){1'b0}}, sd};
                    cnt_q <= '0;
                end else if (take_old) begin
                    sh_q  <= full;
                    cnt_q <= idx;
                    if (idx == cap_idx) begin
                        smp_valid <= 1'b1;
                        smp_word  <= full << (SMP_W - nbits);
                        smp_right <= chan_q;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sarx_rxreg.sv
module sarx_rxreg
    import sarx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SMP_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_word,
    input  logic              smp_right,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              rx_right,
    output logic              rx_overrun
);
    rx_state_e         st_q, st_d;
    logic              wide, busy_after, accept, clr_armed_q;
    logic [WORD_W-1:0] word_q, lo_q;
    logic              right_q;

    assign wide       = (fmt_sel != FMT_16);
    assign busy_after = (st_q == RX_TWO) || ((st_q == RX_ONE) && !rd_data);
    assign accept     = smp_valid && !busy_after;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: if (accept) st_d = wide ? RX_TWO : RX_ONE;
            RX_ONE:   if (rd_data) st_d = accept ? (wide ? RX_TWO : RX_ONE) : RX_EMPTY;
            RX_TWO:   if (rd_data) st_d = RX_ONE;
            default:  st_d = RX_EMPTY;
        endcase
    end

    // Register contents and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q      <= '0;
            lo_q        <= '0;
            right_q     <= 1'b0;
            rx_overrun  <= 1'b0;
            clr_armed_q <= 1'b0;
        end else begin
            if (accept) begin
                word_q  <= smp_word[SMP_W-1 -: WORD_W];
                lo_q    <= smp_word[WORD_W-1:0];
                right_q <= smp_right;
            end else if ((st_q == RX_TWO) && rd_data) begin
                word_q  <= lo_q;
            end
            if (smp_valid && !accept)          rx_overrun <= 1'b1;
            else if (rd_data && clr_armed_q)   rx_overrun <= 1'b0;
            if (rd_data)                       clr_armed_q <= 1'b0;
            else if (rd_status && rx_overrun)  clr_armed_q <= 1'b1;
        end
    end

    assign rx_word  = word_q;
    assign rx_right = right_q;
    assign rx_ready = (st_q != RX_EMPTY);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic [1:0]        std_sel,
    input  logic [1:0]        fmt_sel,
    input  logic              slot32,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              rx_right,
    output logic              rx_overrun
);
    localparam int SMP_W = 2 * WORD_W;

    logic             smp_valid;
    logic [SMP_W-1:0] smp_word;
    logic             smp_right;

    sarx_framer #(.SMP_W(SMP_W), .HALF_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .master    (master),
        .std_sel   (std_sel),
        .fmt_sel   (fmt_sel),
        .slot32    (slot32),
        .sck       (sck),
        .ws        (ws),
        .sd        (sd),
        .smp_valid (smp_valid),
        .smp_word  (smp_word),
        .smp_right (smp_right)
    );

    sarx_rxreg #(.WORD_W(WORD_W), .SMP_W(SMP_W)) u_rxreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .smp_valid  (smp_valid),
        .smp_word   (smp_word),
        .smp_right  (smp_right),
        .rd_status  (rd_status),
        .rd_data    (rd_data),
        .rx_word    (rx_word),
        .rx_ready   (rx_ready),
        .rx_right   (rx_right),
        .rx_overrun (rx_overrun)
    );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [1:0]        std_sel,
    input logic              smp_valid,
    input logic              rd_data,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_ready,
    input logic              rx_right,
    input logic              rx_overrun
);
    assert_ready_from_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(smp_valid));

    assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_data) |=> rx_ready);

    assert_overrun_keeps_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rx_ready && !rd_data) |=> $stable(rx_word));

    assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rx_ready && !rd_data) |=> rx_overrun);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rd_data) |=> rx_overrun);

    assert_pcm_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_ready) && (std_sel == 2'd3) && ($past(std_sel) == 2'd3)) |-> !rx_right);

    assert_idle_no_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !smp_valid);

endmodule

bind serial_audio_rx sarx_checker #(.WORD_W(WORD_W)) u_sarx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .std_sel    (std_sel),
    .smp_valid  (smp_valid),
    .rd_data    (rd_data),
    .rx_word    (rx_word),
    .rx_ready   (rx_ready),
    .rx_right   (rx_right),
    .rx_overrun (rx_overrun)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, master = 1'b0, slot32 = 1'b0;
    logic [1:0]  std_sel = 2'd0, fmt_sel = 2'd0;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic        rd_status = 1'b0, man_rd = 1'b0, auto_rd = 1'b0;
    logic        rd_data;
    logic [15:0] rx_word;
    logic        rx_ready, rx_right, rx_overrun;

    int          n_chk = 0, n_bad = 0;
    bit          collect = 1'b0;
    int          ngot = 0;
    logic [15:0] got_w [64];
    logic        got_c [64];
    logic [15:0] exp_w [64];
    logic        exp_c [64];
    logic [31:0] smp [8];

    assign rd_data = man_rd | auto_rd;

    always #5 clk = ~clk;

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .std_sel(std_sel),
        .fmt_sel(fmt_sel), .slot32(slot32), .sck(sck), .ws(ws), .sd(sd),
        .rd_status(rd_status), .rd_data(rd_data), .rx_word(rx_word),
        .rx_ready(rx_ready), .rx_right(rx_right), .rx_overrun(rx_overrun)
    );

    // Automatic reader: takes every word as soon as it is offered.
    always @(negedge clk) begin
        auto_rd = 1'b0;
        if (collect && rx_ready && ngot < 64) begin
            got_w[ngot] = rx_word;
            got_c[ngot] = rx_right;
            ngot = ngot + 1;
            auto_rd = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = d;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); man_rd = 1'b1;
        @(negedge clk); man_rd = 1'b0;
    endtask

    task automatic pulse_status();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
    endtask

    function automatic logic dbit(input logic [1:0] s, input logic [31:0] v,
                                  input int j, input int nb, input int sl);
        if (s == 2'd2) return (j >= sl - nb) ? v[sl-1-j] : 1'b1;
        return (j < nb) ? v[nb-1-j] : 1'b1;
    endfunction

    // Sends nsl slots of smp[] with the framing of the current settings.
    task automatic send_stream(input int nsl, input int c0, input bit pre);
        int nb, sl, gd, slot;
        logic w, d;
        bit late;
        nb   = (fmt_sel == 2'd0) ? 16 : ((fmt_sel == 2'd1) ? 24 : 32);
        sl   = (slot32 || nb > 16) ? 32 : 16;
        late = (std_sel == 2'd0) || (std_sel == 2'd3);
        if (pre) begin
            if (std_sel == 2'd3) begin
                send_bit(1'b1, 1'b1);
                repeat (sl) send_bit(1'b0, 1'b1);
            end else begin
                repeat (sl + 1) send_bit(1'b0, 1'b1);
            end
        end
        for (int g = 0; g <= nsl * sl; g++) begin
            slot = g / sl;
            if (std_sel == 2'd3) w = ((g % sl) == 0);
            else                 w = 1'((c0 + slot) % 2);
            gd = late ? g - 1 : g;
            if (gd < 0 || gd >= nsl * sl) d = 1'b1;
            else                          d = dbit(std_sel, smp[gd / sl], gd % sl, nb, sl);
            send_bit(w, d);
        end
        @(negedge clk); sck = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic setup(input logic m, input logic [1:0] s, input logic [1:0] f,
                         input logic sl, input int seed);
        int nb;
        logic [31:0] mask;
        @(negedge clk);
        en = 1'b0; master = m; std_sel = s; fmt_sel = f; slot32 = sl;
        sck = 1'b0; ws = 1'b0; sd = 1'b0;
        nb   = (f == 2'd0) ? 16 : ((f == 2'd1) ? 24 : 32);
        mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
        for (int i = 0; i < 8; i++)
            smp[i] = (32'h9E37_79B1 * (i + 1) + 32'h0101_0101 * seed + 32'h8000_0000 * (i % 2)) & mask;
        repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cfg(input logic m, input logic [1:0] s, input logic [1:0] f,
                           input logic sl, input int seed);
        int nb, ne, c0, ch;
        logic [31:0] al;
        string tag;
        setup(m, s, f, sl, seed);
        nb = (f == 2'd0) ? 16 : ((f == 2'd1) ? 24 : 32);
        c0 = m ? 0 : 1;
        ne = 0;
        for (int i = 0; i < 4; i++) begin
            ch = (s == 2'd3) ? 0 : ((c0 + i) % 2);
            al = smp[i] << (32 - nb);
            exp_w[ne] = al[31:16]; exp_c[ne] = 1'(ch); ne++;
            if (nb > 16) begin
                exp_w[ne] = al[15:0]; exp_c[ne] = 1'(ch); ne++;
            end
        end
        ngot = 0;
        collect = 1'b1;
        send_stream(4, c0, !m);
        collect = 1'b0;
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        // R10 (slave garbage slot ignored) and R6 (one read per word)
        check(ngot == ne, m ? "R6 word count" : "R10 word count", 32'(ngot), 32'(ne));
        unique case (s)
            2'd0:    tag = "R2";
            2'd1:    tag = "R1";
            2'd2:    tag = "R4";
            default: tag = "R5";
        endcase
        if (nb > 16) tag = {tag, "/R7"};
        for (int k = 0; k < ne; k++) begin
            check(got_w[k] == exp_w[k], {tag, " word"}, 32'(got_w[k]), 32'(exp_w[k]));
            check(got_c[k] == exp_c[k], (s == 2'd3) ? "R5 side" : "R3 side",
                  32'(got_c[k]), 32'(exp_c[k]));
        end
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rx_word == 16'h0 && !rx_ready && !rx_right && !rx_overrun,
              "R11 reset", {13'h0, rx_ready, rx_right, rx_overrun, rx_word}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int f = 0; f < 3; f++)
                    for (int sl = 0; sl < 2; sl++)
                        run_cfg(1'(m), 2'(s), 2'(f), 1'(sl), m * 24 + s * 6 + f * 2 + sl);

        // R8/R9 with one word held: second sample arrives unread.
        setup(1'b1, 2'd0, 2'd0, 1'b0, 77);
        send_stream(2, 0, 1'b0);
        check(rx_ready, "R6 held ready", 32'(rx_ready), 32'd1);
        check(rx_word == smp[0][15:0], "R8 old word kept", 32'(rx_word), 32'(smp[0][15:0]));
        check(rx_overrun, "R8 overrun set", 32'(rx_overrun), 32'd1);
        pulse_rd();
        check(rx_overrun, "R9 data read alone keeps flag", 32'(rx_overrun), 32'd1);
        check(!rx_ready, "R6 ready cleared by read", 32'(rx_ready), 32'd0);
        pulse_status();
        check(rx_overrun, "R9 status read alone keeps flag", 32'(rx_overrun), 32'd1);
        pulse_rd();
        check(!rx_overrun, "R9 status then data clears", 32'(rx_overrun), 32'd0);

        // R8 with a second word queued (32-bit sample).
        setup(1'b1, 2'd0, 2'd2, 1'b1, 91);
        send_stream(2, 0, 1'b0);
        check(rx_word == smp[0][31:16], "R7 high word first", 32'(rx_word), 32'(smp[0][31:16]));
        check(rx_overrun, "R8 overrun while queued", 32'(rx_overrun), 32'd1);
        pulse_rd();
        check(rx_word == smp[0][15:0] && rx_ready, "R8 queued low word kept",
              {15'h0, rx_ready, rx_word}, {15'h0, 1'b1, smp[0][15:0]});
        pulse_rd();
        check(!rx_ready, "R6 empty after both words", 32'(rx_ready), 32'd0);
        pulse_status();
        pulse_rd();
        check(!rx_overrun, "R9 cleared", 32'(rx_overrun), 32'd0);

        // R12 disabled: activity ignored.
        @(negedge clk); en = 1'b0; master = 1'b1; std_sel = 2'd1; fmt_sel = 2'd0; slot32 = 1'b0;
        held = rx_word;
        for (int g = 0; g < 48; g++) send_bit(1'((g / 16) % 2), 1'(g % 3 == 0));
        repeat (4) @(negedge clk);
        check(!rx_ready, "R12 no ready while disabled", 32'(rx_ready), 32'd0);
        check(rx_word == held, "R12 word unchanged", 32'(rx_word), 32'(held));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule